// File: doc/BRIEF.md
# Frame Buffer Rectangle Fill Engine

This block paints a solid rectangle into a 1024 x 512 halfword frame buffer. Software hands it a packet of three 32-bit words over a plain valid/ready command port:

- a colour word, whose top byte is the command byte;
- a corner word;
- a size word.

Once the third word is taken, the engine reduces the 24-bit colour to a 15-bit pixel. It snaps the horizontal extent to 16-halfword tiles. It then walks the rectangle one halfword write at a time on a request/acknowledge memory port. While the walk runs, `busy` is high and the command port is closed. A single-cycle `done` pulse marks the end.

The engine never reads the frame buffer. It writes every pixel in the rectangle, whatever is already stored there. The command byte is carried but not decoded: any three accepted words form one fill packet. Address = Y * 1024 + X.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low and `cmd_ready` is high.
- R2: A word is accepted on a rising edge with `cmd_valid` and `cmd_ready` both high. The words are taken in the order colour, corner, size. `busy` is high from the cycle after the third word is accepted.
- R3: The colour word holds red in bits 7-0, green in 15-8 and blue in 23-16. The pixel written keeps the upper 5 bits of each channel: red in pixel bits 4-0, green in 9-5 and blue in 14-10.
- R4: Pixel bit 15 is always 0. Every pixel of the rectangle is overwritten regardless of its previous content.
- R5: X comes from corner bits 9-0 and is rounded down to a multiple of 16. Corner bits 15-10 are ignored.
- R6: Width comes from size bits 15-0 and is rounded up to a multiple of 16. Height comes from size bits 31-16.
- R7: Writes go row by row starting at Y (corner bits 24-16). Within a row they go left to right. Each address is Y * 1024 + X.
- R8: X wraps modulo 1024 within a row and Y wraps modulo 512 between rows. Corner bits 31-25 are ignored.
- R9: While `mem_req` is high without `mem_ack`, the request, address and data hold unchanged into the next cycle.
- R10: `done` is high for exactly one cycle, the cycle after the final acknowledged write. `busy` is high in that cycle and low in the next.
- R11: A width or height of zero produces no write. The cycle after the third word, `busy` and `done` are both high for one cycle.
- R12: `cmd_ready` is low whenever `busy` is high, so words offered during a fill are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_data | input | 32 | Command word |
| cmd_ready | output | 1 | Engine can take a command word |
| mem_req | output | 1 | Halfword write request |
| mem_addr | output | 19 | Halfword address, Y in upper 9 bits, X in lower 10 |
| mem_wdata | output | 16 | Pixel to write |
| mem_ack | input | 1 | Write accepted on this edge |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The fill is tried with several packet shapes, each against an irregular acknowledge pattern, so held requests are separated from accepted ones:

- **Small unaligned fill:** unaligned X and a width not a multiple of 16 separate correct tile rounding from plain truncation.
- **Exact-tile fill:** X and width already on tile boundaries show that rounding adds nothing when none is due.
- **Corner-wrap fill:** a rectangle near the right and bottom edges, with junk in the unused corner bits, shows both wraps and the masking of the upper fields.
- **Colour extremes:** all ones and sub-threshold channels expose truncation versus rounding of the channels.
- **Empty fills:** zero-width and zero-height packets confirm the no-write path.
- **Junk during a fill:** words held on the port through a whole fill confirm that the packet framing survives.

// File: rtl/fill_pkg.sv
package fill_pkg;

  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_WRITE  = 2'd1,
    FS_FINISH = 2'd2
  } fill_state_e;

  // 8:8:8 to 1:5:5:5, top bit cleared, upper five bits of each channel kept
  function automatic logic [15:0] rgb24_to_pix(input logic [23:0] rgb);
    return {1'b0, rgb[23:19], rgb[15:11], rgb[7:3]};
  endfunction

endpackage

// File: rtl/fill_pkt_capture.sv
module fill_pkt_capture #(
  parameter int PKT_WORDS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_data,
  input  logic        accept_en,
  output logic        launch,
  output logic [23:0] colour,
  output logic [31:0] corner,
  output logic [31:0] size
);
  localparam int IDX_W = $clog2(PKT_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PKT_WORDS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             accept;
  logic             colour_en, corner_en;
  logic [23:0]      colour_q;
  logic [31:0]      corner_q;

  assign accept    = cmd_valid && accept_en;
  assign launch    = accept && (idx_q == IDX_LAST);
  assign colour_en = accept && (idx_q == '0);
  assign corner_en = accept && (idx_q == IDX_W'(1));

  always_comb begin
    idx_d = idx_q;
    if (accept) begin
      if (idx_q == IDX_LAST) idx_d = '0;
      else                   idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         colour_q <= '0;
    else if (colour_en) colour_q <= cmd_data[23:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         corner_q <= '0;
    else if (corner_en) corner_q <= cmd_data;
  end

  assign colour = colour_q;
  assign corner = corner_q;
  assign size   = cmd_data;
endmodule

// File: rtl/fill_pix_convert.sv
module fill_pix_convert
  import fill_pkg::*;
(
  input  logic [23:0] colour,
  output logic [15:0] pixel
);
  assign pixel = rgb24_to_pix(colour);
endmodule

// File: rtl/fill_walker.sv
module fill_walker
  import fill_pkg::*;
#(
  parameter int X_BITS    = 10,
  parameter int Y_BITS    = 9,
  parameter int TILE_LOG2 = 4,
  parameter int DIM_BITS  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch,
  input  logic [31:0]              corner,
  input  logic [31:0]              size,
  input  logic [15:0]              pix_in,
  input  logic                     mem_ack,
  output logic                     mem_req,
  output logic [X_BITS+Y_BITS-1:0] mem_addr,
  output logic [15:0]              mem_wdata,
  output logic                     busy,
  output logic                     done,
  output logic                     idle
);
  localparam int CNT_W = DIM_BITS + 1;

  fill_state_e         state_q, state_d;
  logic [X_BITS-1:0]   x_start, x_base_q, x_q, x_d;
  logic [Y_BITS-1:0]   y_start, y_q, y_d;
  logic [DIM_BITS-1:0] w_raw, h_raw;
  logic [CNT_W-1:0]    cols_round;
  logic [CNT_W-1:0]    col_q, col_d, col_last_q;
  logic [DIM_BITS-1:0] row_q, row_d, row_last_q;
  logic [15:0]         pix_q;
  logic                empty, load_en, step_en, row_end, last_px;

  assign w_raw   = size[DIM_BITS-1:0];
  assign h_raw   = size[16 +: DIM_BITS];
  assign y_start = corner[16 +: Y_BITS];
  assign empty   = (w_raw == '0) || (h_raw == '0);

  generate
    if (TILE_LOG2 > 0) begin : g_tiled
      localparam logic [CNT_W-1:0]  CMASK = CNT_W'((1 << TILE_LOG2) - 1);
      localparam logic [X_BITS-1:0] XMASK = X_BITS'((1 << TILE_LOG2) - 1);
      assign cols_round = ({1'b0, w_raw} + CMASK) & ~CMASK;
      assign x_start    = corner[X_BITS-1:0] & ~XMASK;
    end else begin : g_plain
      assign cols_round = {1'b0, w_raw};
      assign x_start    = corner[X_BITS-1:0];
    end
  endgenerate

  assign load_en = (state_q == FS_IDLE) && launch;
  assign step_en = (state_q == FS_WRITE) && mem_ack;
  assign row_end = (col_q == col_last_q);
  assign last_px = row_end && (row_q == row_last_q);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE:   if (launch)  state_d = empty ? FS_FINISH : FS_WRITE;
      FS_WRITE:  if (mem_ack && last_px) state_d = FS_FINISH;
      FS_FINISH: state_d = FS_IDLE;
      default:   state_d = FS_IDLE;
    endcase
  end

  // next position
  always_comb begin
    if (load_en) begin
      x_d   = x_start;
      y_d   = y_start;
      col_d = '0;
      row_d = '0;
    end else if (row_end) begin
      x_d   = x_base_q;
      y_d   = y_q + 1'b1;
      col_d = '0;
      row_d = row_q + 1'b1;
    end else begin
      x_d   = x_q + 1'b1;
      y_d   = y_q;
      col_d = col_q + 1'b1;
      row_d = row_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_base_q   <= '0;
      col_last_q <= '0;
      row_last_q <= '0;
      pix_q      <= '0;
    end else if (load_en) begin
      x_base_q   <= x_start;
      col_last_q <= cols_round - 1'b1;
      row_last_q <= h_raw - 1'b1;
      pix_q      <= pix_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      col_q <= '0;
      row_q <= '0;
    end else if (load_en || step_en) begin
      x_q   <= x_d;
      y_q   <= y_d;
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign mem_req   = (state_q == FS_WRITE);
  assign mem_addr  = {y_q, x_q};
  assign mem_wdata = pix_q;
  assign busy      = (state_q != FS_IDLE);
  assign done      = (state_q == FS_FINISH);
  assign idle      = (state_q == FS_IDLE);
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine #(
  parameter int X_BITS    = 10,
  parameter int Y_BITS    = 9,
  parameter int TILE_LOG2 = 4,
  parameter int DIM_BITS  = 16,
  parameter int SYNC_LEN  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [31:0]              cmd_data,
  output logic                     cmd_ready,
  output logic                     mem_req,
  output logic [X_BITS+Y_BITS-1:0] mem_addr,
  output logic [15:0]              mem_wdata,
  input  logic                     mem_ack,
  output logic                     busy,
  output logic                     done
);
  logic [SYNC_LEN-1:0] rst_pipe_q;
  logic                rst_int_n;
  logic                launch, idle;
  logic [23:0]         colour;
  logic [31:0]         corner, size;
  logic [15:0]         pixel;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_LEN-1];

  fill_pkt_capture #(.PKT_WORDS(3)) u_capture (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .accept_en (idle),
    .launch    (launch),
    .colour    (colour),
    .corner    (corner),
    .size      (size)
  );

  fill_pix_convert u_convert (
    .colour (colour),
    .pixel  (pixel)
  );

  fill_walker #(
    .X_BITS    (X_BITS),
    .Y_BITS    (Y_BITS),
    .TILE_LOG2 (TILE_LOG2),
    .DIM_BITS  (DIM_BITS)
  ) u_walker (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .launch    (launch),
    .corner    (corner),
    .size      (size),
    .pix_in    (pixel),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .idle      (idle)
  );

  assign cmd_ready = idle;
endmodule

// File: rtl/rect_fill_checker.sv
module rect_fill_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              mem_ack,
  input logic              busy,
  input logic              done
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done && cmd_ready));

  a_r4_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_wdata[15]);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !mem_req));

  a_r12_port_closed: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
endmodule

bind rect_fill_engine rect_fill_checker #(.ADDR_W(X_BITS + Y_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .busy      (busy),
  .done      (done)
);

// File: tb/rect_fill_engine_test.sv
module rect_fill_engine_test;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic        cmd_ready;
  logic        mem_req;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack;
  logic        busy;
  logic        done;

  int vectors  = 0;
  int failures = 0;
  int cycles   = 0;
  int ack_seq  = 0;
  bit run_chk  = 0;
  bit exp_done = 0;
  int q_addr[$];
  int q_data[$];
  logic [15:0] mem [int];

  rect_fill_engine uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .done      (done)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_pix(input int rgb);
    int r = rgb & 255;
    int g = (rgb >> 8) & 255;
    int b = (rgb >> 16) & 255;
    return ((b >> 3) << 10) | ((g >> 3) << 5) | (r >> 3);
  endfunction

  // cycle-by-cycle reference, compared at every falling edge
  always @(negedge clk) begin
    bit nd;
    bit eb;
    nd = 0;
    cycles++;
    if (run_chk) begin
      eb = (q_addr.size() > 0) || exp_done;
      chk(busy == eb, "R2/R10 busy", busy, eb);
      chk(done == exp_done, "R10/R11 done", done, exp_done);
      chk(mem_req == (q_addr.size() > 0), "R7/R11 mem_req", mem_req, q_addr.size() > 0);
      chk(cmd_ready == !eb, "R12 cmd_ready", cmd_ready, !eb);
      mem_ack = 0;
      if (mem_req && q_addr.size() > 0) begin
        ack_seq++;
        if (((ack_seq * 7) % 5) != 0) begin
          mem_ack = 1;
          chk(int'(mem_addr) == q_addr[0], "R5/R6/R7/R8 address", mem_addr, q_addr[0]);
          chk(int'(mem_wdata) == q_data[0], "R3/R4 pixel", mem_wdata, q_data[0]);
          mem[int'(mem_addr)] = mem_wdata;
          void'(q_addr.pop_front());
          void'(q_data.pop_front());
          if (q_addr.size() == 0) nd = 1;
        end
      end
      exp_done = nd;
    end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end

  task automatic fill(input int colour, input int corner, input int size, input bit junk);
    int xs, ys, w, h, pix;
    int words[3];
    words[0] = 32'h0200_0000 | (colour & 32'h00FF_FFFF);
    words[1] = corner;
    words[2] = size;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2;
      cmd_valid = 1;
      cmd_data  = words[i];
    end
    @(posedge clk); #2;
    xs  = (corner & 1023) & ~15;
    ys  = (corner >> 16) & 511;
    w   = (((size & 16'hFFFF) + 15) / 16) * 16;
    h   = (size >> 16) & 16'hFFFF;
    pix = ref_pix(colour);
    if (w == 0 || h == 0) exp_done = 1;
    else
      for (int r = 0; r < h; r++)
        for (int c = 0; c < w; c++) begin
          q_addr.push_back(((ys + r) % 512) * 1024 + ((xs + c) % 1024));
          q_data.push_back(pix);
        end
    if (junk) cmd_data = 32'hDEAD_BEEF;
    else      cmd_valid = 0;
    while (q_addr.size() > 0 || exp_done || busy) begin
      @(posedge clk); #2;
    end
    cmd_valid = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_data = '0; mem_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req && cmd_ready, "R1 reset outputs",
        {busy, done, mem_req, cmd_ready}, 4'b0001);
    @(posedge clk); #2 rst_n = 1;
    repeat (4) @(posedge clk);
    run_chk = 1;

    // R4: pre-load stale pixels with the top bit set
    for (int r = 0; r < 2; r++)
      for (int c = 32; c < 64; c++) mem[(5 + r) * 1024 + c] = 16'hFFFF;
    // R5/R6 unaligned X and width: X 35 -> 32, width 20 -> 32
    fill(32'h0012_3456, (5 << 16) | 35, (2 << 16) | 20, 0);
    for (int r = 0; r < 2; r++)
      for (int c = 32; c < 64; c++)
        chk(mem[(5 + r) * 1024 + c] == 16'(ref_pix(32'h12_3456)), "R4 overwrite",
            mem[(5 + r) * 1024 + c], ref_pix(32'h12_3456));

    // exact tile, three rows; R3 all-ones colour gives 7FFF
    fill(32'h00FF_FFFF, (100 << 16) | 64, (3 << 16) | 16, 0);
    chk(mem[102 * 1024 + 79] == 16'h7FFF, "R3 white pixel", mem[102 * 1024 + 79], 16'h7FFF);

    // R3 channel truncation: 07 per channel gives 0; 08/10/F8 mix
    fill(32'h0007_0707, (7 << 16) | 0, (1 << 16) | 1, 0);
    chk(mem[7 * 1024] == 16'h0000, "R3 truncation", mem[7 * 1024], 0);
    fill(32'h00F8_1008, (8 << 16) | 16, (1 << 16) | 16, 0);
    chk(mem[8 * 1024 + 16] == 16'h7C41, "R3 field order", mem[8 * 1024 + 16], 16'h7C41);

    // R8 wrap in X and Y with junk in the unused corner fields
    fill(32'h0000_1F00, 32'hFE00_0000 | (511 << 16) | 32'hFC00 | 1020, (2 << 16) | 32, 0);
    chk(mem[0 * 1024 + 15] == 16'(ref_pix(32'h1F00)), "R8 wrapped pixel",
        mem[15], ref_pix(32'h1F00));

    // R11 empty fills
    fill(32'h0011_2233, (1 << 16) | 1, (5 << 16) | 0, 0);
    fill(32'h0011_2233, (1 << 16) | 1, (0 << 16) | 9, 0);

    // R12 junk held during a fill must not shift packet framing
    fill(32'h0000_00FF, (20 << 16) | 200, (2 << 16) | 17, 1);
    fill(32'h0000_FF00, (30 << 16) | 300, (1 << 16) | 16, 0);
    chk(mem[30 * 1024 + 300] == 16'h03E0, "R12 framing after junk",
        mem[30 * 1024 + 300], 16'h03E0);

    repeat (5) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end
endmodule